// File: doc/BRIEF.md
# Data Cache Control and Way-Lock Victim Selector

This block holds the control state of a 4-way set-associative data cache and decides which way each line fill writes. A bus-visible control register carries the cache enable, the two write-policy selectors and a self-clearing flush trigger. A separate lock register, which can only be written and only while the cache is disabled, can pin prefetch fills to way 2 or way 3. The pinning applies only while the DSP flag (bit 12 of the CPU status word) is set.

Per set, the block keeps four valid bits, four dirty bits and a 3-bit pseudo-LRU tree. The tag and data arrays sit outside the block. A lookup arrives as a set index plus hit/miss information. On a miss, the block reports the chosen fill way and whether that way holds valid or dirty data.

A flush is run by a two-state machine. FL_IDLE moves to FL_SWEEP when a control write sets the flush bit. FL_SWEEP clears one set per clock. It returns to FL_IDLE after clearing the last set. While the machine is in FL_SWEEP, `busy` is high and lookups are stalled.

Top module: `dcache_ctl`

## Requirements
- R1: Reading the control register (`reg_sel`=0) returns cache enable in bit 0, write-through select in bit 1 and write-back select in bit 2. All other bits read 0, including the flush bit 3. A control write loads bits 2:0 from the write data. Bits 4 and 5 of the write data have no effect. After reset all control fields are 0.
- R2: Reading the lock register (`reg_sel`=1) always returns 0.
- R3: A lock register write taken while cache enable is 1 is ignored. When cache enable is 0, the write stores write-data bits 9:8 as the high lock field and bits 1:0 as the low lock field.
- R4: A prefetch miss with status bit 12 set fills way 3 when the high lock field is 11. Otherwise, it fills way 2 when the low lock field is 11. Way 3 wins when both fields are 11.
- R5: A prefetch miss with status bit 12 clear, or with neither lock field equal to 11, fills the pseudo-LRU victim way.
- R6: The pseudo-LRU tree per set has three bits. Root bit t0=0 selects ways 0/1 via t1 (way t1). t0=1 selects ways 2/3 via t2 (way 2+t2). Every hit and every fill to way w sets t0 to the inverse of w[1], and sets t1 (for w<2) or t2 (for w>=2) to the inverse of w[0]. Reset leaves the tree at 000.
- R7: An ordinary (non-prefetch) miss with status bit 12 set avoids any way that a lock field of 11 holds. If the victim is locked, it uses the sibling way. If the sibling is also locked, it uses way t1 of the left pair.
- R8: A prefetch that hits issues no fill and changes no valid, dirty or LRU state.
- R9: A control write with bit 3 set while idle raises `busy` for exactly NSETS cycles. While `busy` is high, no fill is issued and lookups change no state.
- R10: A flush clears the valid, dirty and LRU state of every set with no write-back. A fill after a flush picks way 0 and reports `fill_evict_valid`=0.
- R11: A write lookup marks the target way dirty when the region is write-back. For a region P1 access (`lk_p1`=1), write-back applies when the write-back select is 1. For any other region it applies when write-through select is 0. A fill stores that dirty value. `fill_evict_dirty` reports the victim's dirty bit.
- R12: While cache enable is 0, lookups issue no fill and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = lock register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| cpu_status | input | 32 | CPU status word; bit 12 is the DSP flag |
| lk_valid | input | 1 | Lookup request |
| lk_set | input | SET_W | Lookup set index |
| lk_hit | input | 1 | Lookup hit in the tag array |
| lk_way | input | 2 | Way that hit |
| lk_pref | input | 1 | Lookup is a prefetch |
| lk_write | input | 1 | Lookup is a store |
| lk_p1 | input | 1 | Access lies in region P1 |
| busy | output | 1 | Flush sweep in progress; lookups stall |
| fill_valid | output | 1 | A line fill is issued this cycle |
| fill_way | output | 2 | Way the fill writes |
| fill_evict_valid | output | 1 | The fill way holds a valid line |
| fill_evict_dirty | output | 1 | The fill way holds a dirty line |
| cache_en | output | 1 | Cache enable bit |
| wt_mode | output | 1 | Write-through select for P0/U0/P3 |
| cb_mode | output | 1 | Write-back select for P1 |

## Verification
A corrupted LRU tree or valid/dirty bit stays hidden until that set next takes a miss. At that miss, `fill_way`, `fill_evict_valid` or `fill_evict_dirty` differ in the same cycle. The bench therefore replays many fills per set so that stale state surfaces within a few lookups. A wrong flush index or an early exit from FL_SWEEP shows at once as a wrong `busy` length. It shows later as a dirty or valid victim after the flush. A lock field stored when it should have been dropped shows at the next DSP prefetch miss as the wrong way.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

    typedef enum logic [0:0] {
        FL_IDLE  = 1'b0,
        FL_SWEEP = 1'b1
    } flush_state_e;

    typedef logic [2:0] plru_t;

    // Victim named by a 3-bit tree: bit0 picks the pair, bit1/bit2 the member.
    function automatic logic [1:0] plru_victim(input plru_t t);
        return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
    endfunction

    // Point the tree away from the way just used.
    function automatic plru_t plru_touch(input plru_t t, input logic [1:0] w);
        plru_t n;
        n    = t;
        n[0] = ~w[1];
        if (w[1]) n[2] = ~w[0];
        else      n[1] = ~w[0];
        return n;
    endfunction

endpackage

// File: rtl/dc_cfg_regs.sv
module dc_cfg_regs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic        sel,
    input  logic [31:0] wdata,
    output logic        ce,
    output logic        wt,
    output logic        cb,
    output logic [1:0]  lock_hi,
    output logic [1:0]  lock_lo,
    output logic        flush_req,
    output logic [31:0] rdata
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce      <= 1'b0;
            wt      <= 1'b0;
            cb      <= 1'b0;
            lock_hi <= 2'b00;
            lock_lo <= 2'b00;
        end else if (wr) begin
            if (!sel) begin
                ce <= wdata[0];
                wt <= wdata[1];
                cb <= wdata[2];
            end else if (!ce) begin
                lock_hi <= wdata[9:8];
                lock_lo <= wdata[1:0];
            end
        end
    end

    assign flush_req = wr & ~sel & wdata[3];

    always_comb begin
        rdata = '0;
        if (!sel) rdata[2:0] = {cb, wt, ce};
    end

    // R3
    lock_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel && ce) |=> ($stable(lock_hi) && $stable(lock_lo)));

    // R2
    lock_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> (rdata == 32'd0));

    // R1
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !sel) |=> (ce == $past(wdata[0]) && cb == $past(wdata[2])));

endmodule

// File: rtl/dc_flush_fsm.sv
module dc_flush_fsm #(
    parameter int NSETS = 16,
    parameter int SET_W = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             clr_en,
    output logic [SET_W-1:0] clr_idx
);
    import dcache_pkg::*;

    localparam logic [SET_W-1:0] LAST = SET_W'(NSETS - 1);

    flush_state_e     st_q, st_d;
    logic [SET_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FL_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                             idx_q <= '0;
        else if (st_q == FL_SWEEP && idx_q != LAST) idx_q <= idx_q + 1'b1;
        else                                    idx_q <= '0;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FL_IDLE:  if (start) st_d = FL_SWEEP;
            FL_SWEEP: if (idx_q == LAST) st_d = FL_IDLE;
            default:  st_d = FL_IDLE;
        endcase
    end

    always_comb begin
        busy    = (st_q == FL_SWEEP);
        clr_en  = busy;
        clr_idx = idx_q;
    end

    // R9
    sweep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && clr_idx == LAST) |=> !busy);

    // R9
    sweep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && clr_idx == '0));

endmodule

// File: rtl/dc_way_pick.sv
module dc_way_pick (
    input  logic       dsp,
    input  logic       pref,
    input  logic [1:0] lock_hi,
    input  logic [1:0] lock_lo,
    input  logic [2:0] plru,
    output logic [1:0] way,
    output logic [1:0] lru_way
);
    import dcache_pkg::*;

    logic       pin3, pin2;
    logic [1:0] sib;

    function automatic logic is_pinned(input logic [1:0] w, input logic p3, input logic p2);
        return (w == 2'd3 && p3) || (w == 2'd2 && p2);
    endfunction

    always_comb begin
        pin3    = dsp && (lock_hi == 2'b11);
        pin2    = dsp && (lock_lo == 2'b11);
        lru_way = plru_victim(plru);
        sib     = lru_way ^ 2'b01;
        if (pref) begin
            if (pin3)      way = 2'd3;
            else if (pin2) way = 2'd2;
            else           way = lru_way;
        end else begin
            if (!is_pinned(lru_way, pin3, pin2)) way = lru_way;
            else if (!is_pinned(sib, pin3, pin2)) way = sib;
            else                                  way = {1'b0, plru[1]};
        end
    end

endmodule

// File: rtl/dc_set_store.sv
module dc_set_store #(
    parameter int NSETS = 16,
    parameter int SET_W = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en,
    input  logic [SET_W-1:0] clr_idx,
    input  logic [SET_W-1:0] rd_set,
    input  logic             upd_en,
    input  logic [1:0]       upd_way,
    input  logic             upd_fill,
    input  logic             upd_dirty,
    output logic [2:0]       plru_rd,
    output logic [3:0]       valid_rd,
    output logic [3:0]       dirty_rd
);
    import dcache_pkg::*;

    logic [3:0] v_q [NSETS];
    logic [3:0] d_q [NSETS];
    plru_t      t_q [NSETS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSETS; i++) begin
                v_q[i] <= '0;
                d_q[i] <= '0;
                t_q[i] <= '0;
            end
        end else if (clr_en) begin
            v_q[clr_idx] <= '0;
            d_q[clr_idx] <= '0;
            t_q[clr_idx] <= '0;
        end else if (upd_en) begin
            if (upd_fill) begin
                v_q[rd_set][upd_way] <= 1'b1;
                d_q[rd_set][upd_way] <= upd_dirty;
            end else if (upd_dirty) begin
                d_q[rd_set][upd_way] <= 1'b1;
            end
            t_q[rd_set] <= plru_touch(t_q[rd_set], upd_way);
        end
    end

    assign plru_rd  = t_q[rd_set];
    assign valid_rd = v_q[rd_set];
    assign dirty_rd = d_q[rd_set];

    logic             clr_en_d;
    logic [SET_W-1:0] clr_idx_d;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_en_d  <= 1'b0;
            clr_idx_d <= '0;
        end else begin
            clr_en_d  <= clr_en;
            clr_idx_d <= clr_idx;
        end
    end

    // R10
    set_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_d |-> (v_q[clr_idx_d] == 4'd0 && d_q[clr_idx_d] == 4'd0 && t_q[clr_idx_d] == 3'd0));

endmodule

// File: rtl/dcache_ctl.sv
module dcache_ctl #(
    parameter int NSETS = 16,
    parameter int SET_W = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [31:0]      cpu_status,
    input  logic             lk_valid,
    input  logic [SET_W-1:0] lk_set,
    input  logic             lk_hit,
    input  logic [1:0]       lk_way,
    input  logic             lk_pref,
    input  logic             lk_write,
    input  logic             lk_p1,
    output logic             busy,
    output logic             fill_valid,
    output logic [1:0]       fill_way,
    output logic             fill_evict_valid,
    output logic             fill_evict_dirty,
    output logic             cache_en,
    output logic             wt_mode,
    output logic             cb_mode
);
    localparam int DSP_BIT = 12;

    logic [1:0]       lock_hi, lock_lo, lru_way;
    logic             flush_req, clr_en;
    logic [SET_W-1:0] clr_idx;
    logic [2:0]       plru_rd;
    logic [3:0]       valid_rd, dirty_rd;
    logic             dsp, act, upd_en, wback, upd_dirty;
    logic [1:0]       upd_way;

    dc_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
        .ce(cache_en), .wt(wt_mode), .cb(cb_mode), .lock_hi(lock_hi), .lock_lo(lock_lo),
        .flush_req(flush_req), .rdata(reg_rdata)
    );

    dc_flush_fsm #(.NSETS(NSETS), .SET_W(SET_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(flush_req), .busy(busy),
        .clr_en(clr_en), .clr_idx(clr_idx)
    );

    dc_way_pick u_pick (
        .dsp(dsp), .pref(lk_pref), .lock_hi(lock_hi), .lock_lo(lock_lo),
        .plru(plru_rd), .way(fill_way), .lru_way(lru_way)
    );

    dc_set_store #(.NSETS(NSETS), .SET_W(SET_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr_en(clr_en), .clr_idx(clr_idx),
        .rd_set(lk_set), .upd_en(upd_en), .upd_way(upd_way), .upd_fill(!lk_hit),
        .upd_dirty(upd_dirty), .plru_rd(plru_rd), .valid_rd(valid_rd), .dirty_rd(dirty_rd)
    );

    always_comb begin
        dsp              = cpu_status[DSP_BIT];
        act              = lk_valid && cache_en && !busy;
        fill_valid       = act && !lk_hit;
        upd_en           = act && !(lk_pref && lk_hit);
        upd_way          = lk_hit ? lk_way : fill_way;
        wback            = lk_p1 ? cb_mode : !wt_mode;
        upd_dirty        = lk_write && !lk_pref && wback;
        fill_evict_valid = fill_valid && valid_rd[fill_way];
        fill_evict_dirty = fill_valid && dirty_rd[fill_way];
    end

    // R9
    busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !fill_valid);

    // R8
    pref_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_pref && lk_hit) |-> !fill_valid);

    // R12
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cache_en |-> !fill_valid);

    // R5
    plain_lru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !cpu_status[DSP_BIT]) |-> (fill_way == lru_way));

    // R4
    way3_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && lk_pref && cpu_status[DSP_BIT] && lock_hi == 2'b11) |-> (fill_way == 2'd3));

endmodule

// File: tb/dcache_ctl_bench.sv
module dcache_ctl_bench;
    localparam int NS = 16;
    localparam int SW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata, cpu_status = '0;
    logic        lk_valid = 1'b0, lk_hit = 1'b0, lk_pref = 1'b0, lk_write = 1'b0, lk_p1 = 1'b0;
    logic [SW-1:0] lk_set = '0;
    logic [1:0]  lk_way = '0, fill_way;
    logic        busy, fill_valid, fill_evict_valid, fill_evict_dirty, cache_en, wt_mode, cb_mode;

    dcache_ctl #(.NSETS(NS)) u_dcache_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cpu_status(cpu_status), .lk_valid(lk_valid), .lk_set(lk_set),
        .lk_hit(lk_hit), .lk_way(lk_way), .lk_pref(lk_pref), .lk_write(lk_write), .lk_p1(lk_p1),
        .busy(busy), .fill_valid(fill_valid), .fill_way(fill_way),
        .fill_evict_valid(fill_evict_valid), .fill_evict_dirty(fill_evict_dirty),
        .cache_en(cache_en), .wt_mode(wt_mode), .cb_mode(cb_mode)
    );

    always #5 clk = ~clk;

    int total = 0, bad = 0;
    string tag_override = "";

    logic       m_ce = 0, m_wt = 0, m_cb = 0;
    logic [1:0] m_lhi = 0, m_llo = 0;
    logic [3:0] m_v [NS];
    logic [3:0] m_d [NS];
    logic [2:0] m_t [NS];
    int         m_left = 0, m_fi = 0;

    function automatic logic [1:0] victim(input logic [2:0] t);
        if (t[0] == 1'b0) return {1'b0, t[1]};
        return {1'b1, t[2]};
    endfunction

    function automatic logic [2:0] touch(input logic [2:0] t, input logic [1:0] w);
        logic [2:0] r;
        r = t;
        r[0] = !w[1];
        if (w >= 2) r[2] = !w[0]; else r[1] = !w[0];
        return r;
    endfunction

    function automatic logic [1:0] expect_way(input logic dsp, input logic pref, input logic [2:0] t);
        logic p3, p2;
        logic [1:0] v;
        p3 = dsp && m_lhi == 2'b11;
        p2 = dsp && m_llo == 2'b11;
        v = victim(t);
        if (pref) return p3 ? 2'd3 : (p2 ? 2'd2 : v);
        if ((v == 3 && p3) || (v == 2 && p2)) begin
            if (v == 3 && !p2) return 2'd2;
            if (v == 2 && !p3) return 2'd3;
            return {1'b0, t[1]};
        end
        return v;
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        logic dsp, act, efill, wbk, dr;
        logic [1:0] ew, w;
        logic [31:0] erd;
        int s;
        string rq;
        #5;
        s     = int'(lk_set);
        dsp   = cpu_status[12];
        act   = lk_valid && m_ce && (m_left == 0);
        efill = act && !lk_hit;
        ew    = expect_way(dsp, lk_pref, m_t[s]);
        chk(busy == (m_left != 0), "R9", "busy", 32'(busy), 32'(m_left != 0));
        if (m_left != 0)           rq = "R9";
        else if (!m_ce)            rq = "R12";
        else if (lk_pref && lk_hit) rq = "R8";
        else                       rq = "R6";
        if (lk_valid) chk(fill_valid == efill, rq, "fill_valid", 32'(fill_valid), 32'(efill));
        if (efill) begin
            if (tag_override != "") rq = tag_override;
            else if (lk_pref && dsp && (m_lhi == 2'b11 || m_llo == 2'b11)) rq = "R4";
            else if (lk_pref) rq = "R5";
            else if (dsp && (m_lhi == 2'b11 || m_llo == 2'b11)) rq = "R7";
            else rq = "R6";
            chk(fill_way == ew, rq, "fill_way", 32'(fill_way), 32'(ew));
            chk(fill_evict_valid == m_v[s][ew], "R10", "evict_valid", 32'(fill_evict_valid), 32'(m_v[s][ew]));
            chk(fill_evict_dirty == m_d[s][ew], "R11", "evict_dirty", 32'(fill_evict_dirty), 32'(m_d[s][ew]));
        end
        erd = reg_sel ? 32'd0 : {29'd0, m_cb, m_wt, m_ce};
        chk(reg_rdata == erd, reg_sel ? "R2" : "R1", "rdata", reg_rdata, erd);
        @(posedge clk);
        if (m_left > 0) begin
            m_v[m_fi] = '0; m_d[m_fi] = '0; m_t[m_fi] = '0;
            m_fi++; m_left--;
        end else if (reg_wr && !reg_sel && reg_wdata[3]) begin
            m_left = NS; m_fi = 0;
        end
        if (reg_wr) begin
            if (!reg_sel) begin
                m_ce = reg_wdata[0]; m_wt = reg_wdata[1]; m_cb = reg_wdata[2];
            end else if (!m_ce) begin
                m_lhi = reg_wdata[9:8]; m_llo = reg_wdata[1:0];
            end
        end
        if (act && !(lk_pref && lk_hit)) begin
            w   = lk_hit ? lk_way : ew;
            wbk = lk_p1 ? m_cb : !m_wt;
            dr  = lk_write && !lk_pref && wbk;
            if (!lk_hit) begin m_v[s][w] = 1'b1; m_d[s][w] = dr; end
            else if (dr) m_d[s][w] = 1'b1;
            m_t[s] = touch(m_t[s], w);
        end
        #1;
    endtask

    task automatic wr_reg(input logic sel, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    endtask

    task automatic lookup(input int set, input logic hit, input logic [1:0] way,
                          input logic pref, input logic wr, input logic p1);
        lk_valid = 1'b1; lk_set = SW'(set); lk_hit = hit; lk_way = way;
        lk_pref = pref; lk_write = wr; lk_p1 = p1;
        step();
        lk_valid = 1'b0; lk_hit = 1'b0; lk_pref = 1'b0; lk_write = 1'b0;
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NS; i++) begin m_v[i] = '0; m_d[i] = '0; m_t[i] = '0; end
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        step();                                  // R1 reset state
        lookup(0, 0, 0, 0, 0, 0);               // R12 disabled
        wr_reg(1, 32'h0000_0303);               // lock both fields
        reg_sel = 1'b1; step(); reg_sel = 1'b0;  // R2 read of lock register
        wr_reg(0, 32'h0000_0035);               // R1 CE+CB, bits 4/5 ignored
        cpu_status = 32'h0000_1000;
        lookup(0, 0, 0, 1, 0, 0);               // R4 both pinned -> way 3
        wr_reg(1, 32'h0000_0003);               // R3 ignored while enabled
        tag_override = "R3";
        lookup(1, 0, 0, 1, 0, 0);
        tag_override = "";
        lookup(2, 0, 0, 0, 0, 0);               // R7 ordinary miss
        lookup(2, 0, 0, 0, 0, 0);               // R7 both right ways pinned
        lookup(2, 1, 1, 1, 0, 0);               // R8 prefetch hit
        lookup(2, 0, 0, 0, 0, 0);
        cpu_status = 32'h0;
        lookup(3, 0, 0, 1, 0, 0);               // R5 non-DSP prefetch
        for (int i = 0; i < 6; i++) lookup(4, 0, 0, 0, 1, 1);   // R11 dirty via CB
        lookup(5, 0, 0, 0, 1, 0);               // R11 WT=0 write-back
        wr_reg(0, 32'h0000_000D);               // R9 flush
        for (int i = 0; i < NS + 2; i++) lookup(4, 0, 0, 0, 1, 1);
        lookup(5, 0, 0, 0, 0, 0);               // R10 clean after flush
        wr_reg(0, 32'h0000_0000);
        wr_reg(1, 32'h0000_0103);               // high field 01, low 11
        wr_reg(0, 32'h0000_0003);
        cpu_status = 32'h0000_1000;
        lookup(6, 0, 0, 1, 0, 0);               // R4 way 2
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 3) begin
                logic [31:0] d;
                d = $urandom;
                d[0] = ($urandom % 8) != 0;
                d[3] = ($urandom % 3) == 0;
                wr_reg(0, d);
            end else if (r < 5) begin
                wr_reg(1, $urandom);
            end else if (r < 8) begin
                cpu_status = $urandom;
            end else begin
                lookup(int'($urandom % NS), ($urandom % 3) == 0, 2'($urandom),
                       ($urandom % 4) == 0, $urandom % 2, $urandom % 2);
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule